// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave Model

This block behaves like a small serial EEPROM on a three-wire bus with a chip select. It holds 64 words of 16 bits in internal flip-flops and answers to a host that bit-bangs a select line, a serial clock, a data-in line and a data-out line. The host frames each transaction by raising the select line. It clocks in a start bit and then an 8-bit command made of a 2-bit opcode and a 6-bit word address. Depending on the command, it then clocks data in or out. The data-out line rests high while the slave is idle or busy with a completed command, and this serves as a ready indication.

The serial pins are sampled by the system clock, and edges of the serial clock are found by comparing two samples. A rising edge counts only if the select line is high in the same sample. Reads begin with a forced zero and then stream words MSB first. The word address advances after every 16 bits and wraps from the last word to the first, so one read command can walk the whole array. Every command that changes the array passes through a write-enable latch, which a dedicated pair of commands sets and clears.

Top module: `mw_eeprom_slave`

## Requirements
- R1: After reset, do_o is 1, the write-enable latch is clear, and every word reads 0xFFFF.
- R2: A falling edge of cs_i returns the slave to idle from any state, and do_o is 1 afterwards.
- R3: In idle, a serial clock rise with di_i at 0 is ignored. The first rise with di_i at 1 is the start bit.
- R4: After the start bit, 8 bits are shifted in MSB first: bits 7:6 are the opcode and bits 5:0 the word address. Opcode 01 is write, 10 is read, 11 is erase, and 00 is an extended command selected by bits 5:4.
- R5: On the eighth command bit of a read, do_o goes to 0 as a dummy bit. Each later rise then drives the next bit of the addressed word, MSB first.
- R6: After each 16 read bits, the address increments modulo 64 and the next word follows at once. Address 63 is followed by address 0.
- R7: A write (opcode 01) takes 16 data bits MSB first. The word is stored on the sixteenth bit, and only when the write-enable latch is set.
- R8: A write-all (extended 01, bits 5:4 = 01) takes 16 data bits and copies them into all 64 words, but only when the latch is set.
- R9: An erase (opcode 11) sets the addressed word to 0xFFFF, but only when the latch is set.
- R10: An erase-all (extended, bits 5:4 = 10) sets every word to 0xFFFF, but only when the latch is set.
- R11: Extended bits 5:4 = 11 sets the write-enable latch. Extended bits 5:4 = 00 clears it.
- R12: After any command other than read completes, further serial clocks are ignored and do_o stays 1 until cs_i falls.
- R13: Serial clock edges while cs_i is low have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_i | input | 1 | Chip select, active high |
| sck_i | input | 1 | Serial clock; its rising edge is acted on |
| di_i | input | 1 | Serial data in |
| do_o | output | 1 | Serial data out: ready (1), dummy zero, or read data |

## Verification
Each pin change is captured by one sample register, and the command logic acts one system clock later. A change on sck_i or cs_i therefore shows on do_o, or in the array, two system clocks after the pin moves. The bench holds every serial clock phase for three system clocks and reads do_o on the falling system edge at the end of the high phase, which is one cycle after the result is due. After every select release it waits four system clocks before the next transaction, so the return to idle and any array update have already happened when the next command starts.

// File: rtl/mw_pkg.sv
package mw_pkg;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_CMD   = 3'd1,
      ST_WDATA = 3'd2,
      ST_RDATA = 3'd3,
      ST_HOLD  = 3'd4
   } mw_state_e;

   localparam logic [1:0] OP_EXT   = 2'b00;
   localparam logic [1:0] OP_WRITE = 2'b01;
   localparam logic [1:0] OP_READ  = 2'b10;
   localparam logic [1:0] OP_ERASE = 2'b11;

   localparam logic [1:0] EXT_WDIS = 2'b00;
   localparam logic [1:0] EXT_WALL = 2'b01;
   localparam logic [1:0] EXT_EALL = 2'b10;
   localparam logic [1:0] EXT_WEN  = 2'b11;

endpackage

// File: rtl/mw_pin_sampler.sv
module mw_pin_sampler (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_i,
   input  logic sck_i,
   input  logic di_i,
   output logic cs_q,
   output logic di_q,
   output logic sck_rise,
   output logic cs_fall
);

   logic sck_q;
   logic sck_d;
   logic cs_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_q  <= 1'b0;
         sck_q <= 1'b0;
         di_q  <= 1'b0;
         sck_d <= 1'b0;
         cs_d  <= 1'b0;
      end else begin
         cs_q  <= cs_i;
         sck_q <= sck_i;
         di_q  <= di_i;
         sck_d <= sck_q;
         cs_d  <= cs_q;
      end
   end

   // a serial clock rise counts only with select high in the same sample
   assign sck_rise = sck_q & ~sck_d & cs_q;
   assign cs_fall  = cs_d & ~cs_q;

   // R13
   cs_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(cs_i) && !cs_i) |=> !sck_rise);

endmodule

// File: rtl/mw_word_array.sv
module mw_word_array #(
   parameter int ADDR_W = 6,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_one,
   input  logic              wr_all,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data
);

   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] words [DEPTH];

   for (genvar i = 0; i < DEPTH; i++) begin : g_word
      logic [DATA_W-1:0] word_q;
      logic              hit;

      assign hit = wr_all | (wr_one & (wr_addr == ADDR_W'(i)));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   word_q <= '1;
         else if (hit) word_q <= wr_data;
      end

      assign words[i] = word_q;
   end

   assign rd_data = words[rd_addr];

   // R8
   fill_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_all |=> (rd_data == $past(wr_data)));

   // R7
   single_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_one ##1 (rd_addr == $past(wr_addr))) |-> (rd_data == $past(wr_data)));

endmodule

// File: rtl/mw_cmd_fsm.sv
module mw_cmd_fsm
   import mw_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sck_rise,
   input  logic              cs_fall,
   input  logic              di_q,
   input  logic [DATA_W-1:0] rd_data,
   output logic              do_o,
   output logic              wr_one,
   output logic              wr_all,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [DATA_W-1:0] wr_data,
   output logic [ADDR_W-1:0] rd_addr
);

   localparam int CMD_W   = 2 + ADDR_W;
   localparam int CNT_MAX = (DATA_W > CMD_W) ? DATA_W : CMD_W;
   localparam int CNT_W   = $clog2(CNT_MAX);
   localparam logic [CNT_W-1:0] CMD_LAST  = CNT_W'(CMD_W - 1);
   localparam logic [CNT_W-1:0] WORD_LAST = CNT_W'(DATA_W - 1);

   mw_state_e         state;
   logic [CNT_W-1:0]  cnt;
   logic [CMD_W-1:0]  cmd_sr;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] buf_q;
   logic              fill_q;
   logic              we_q;
   logic              do_q;

   logic [CMD_W-1:0]  cmd_next;
   logic [1:0]        op;
   logic [1:0]        ext;
   logic [ADDR_W-1:0] cmd_addr;
   logic [DATA_W-1:0] word_next;
   logic              cmd_done;
   logic              word_done;

   assign cmd_next  = {cmd_sr[CMD_W-2:0], di_q};
   assign op        = cmd_next[CMD_W-1 -: 2];
   assign ext       = cmd_next[ADDR_W-1 -: 2];
   assign cmd_addr  = cmd_next[ADDR_W-1:0];
   assign word_next = {buf_q[DATA_W-2:0], di_q};
   assign cmd_done  = sck_rise && (state == ST_CMD) && (cnt == CMD_LAST);
   assign word_done = sck_rise && (state == ST_WDATA) && (cnt == WORD_LAST);

   // array strobes, all gated by the write-enable latch
   always_comb begin
      wr_one  = 1'b0;
      wr_all  = 1'b0;
      wr_addr = addr_q;
      wr_data = word_next;
      if (we_q) begin
         if (cmd_done && op == OP_ERASE) begin
            wr_one  = 1'b1;
            wr_addr = cmd_addr;
            wr_data = '1;
         end else if (cmd_done && op == OP_EXT && ext == EXT_EALL) begin
            wr_all  = 1'b1;
            wr_data = '1;
         end else if (word_done) begin
            wr_one = !fill_q;
            wr_all = fill_q;
         end
      end
   end

   assign rd_addr = (state == ST_CMD) ? cmd_addr : ADDR_W'(addr_q + 1'b1);
   assign do_o    = do_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         cnt    <= '0;
         cmd_sr <= '0;
         addr_q <= '0;
         buf_q  <= '0;
         fill_q <= 1'b0;
         we_q   <= 1'b0;
         do_q   <= 1'b1;
      end else if (cs_fall) begin
         state <= ST_IDLE;
         cnt   <= '0;
         do_q  <= 1'b1;
      end else if (sck_rise) begin
         unique case (state)
            ST_IDLE: begin
               if (di_q) begin
                  state  <= ST_CMD;
                  cnt    <= '0;
                  cmd_sr <= '0;
               end
            end
            ST_CMD: begin
               cmd_sr <= cmd_next;
               cnt    <= cnt + 1'b1;
               if (cnt == CMD_LAST) begin
                  cnt    <= '0;
                  addr_q <= cmd_addr;
                  unique case (op)
                     OP_WRITE: begin
                        state  <= ST_WDATA;
                        fill_q <= 1'b0;
                     end
                     OP_READ: begin
                        state <= ST_RDATA;
                        buf_q <= rd_data;
                        do_q  <= 1'b0;
                     end
                     OP_ERASE: state <= ST_HOLD;
                     default: begin
                        if (ext == EXT_WALL) begin
                           state  <= ST_WDATA;
                           fill_q <= 1'b1;
                        end else begin
                           state <= ST_HOLD;
                           if (ext != EXT_EALL) we_q <= ext[0];
                        end
                     end
                  endcase
               end
            end
            ST_WDATA: begin
               buf_q <= word_next;
               cnt   <= cnt + 1'b1;
               if (cnt == WORD_LAST) state <= ST_HOLD;
            end
            ST_RDATA: begin
               do_q  <= buf_q[DATA_W-1];
               buf_q <= buf_q << 1;
               cnt   <= cnt + 1'b1;
               if (cnt == WORD_LAST) begin
                  cnt    <= '0;
                  addr_q <= ADDR_W'(addr_q + 1'b1);
                  buf_q  <= rd_data;
               end
            end
            default: ;
         endcase
      end
   end

   // R2
   cs_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cs_fall |=> (do_q && state == ST_IDLE));

   // R12
   hold_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_HOLD && !cs_fall) |=> (state == ST_HOLD && do_q));

   // R7
   write_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_one || wr_all) |-> we_q);

   // R5
   dummy_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_RDATA && $past(state) == ST_CMD) |-> !do_q);

   // R4
   cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CNT_W'(CNT_MAX - 1));

   // R8
   strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({wr_one, wr_all}));

endmodule

// File: rtl/mw_eeprom_slave.sv
module mw_eeprom_slave #(
   parameter int ADDR_W = 6,
   parameter int DATA_W = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_i,
   input  logic sck_i,
   input  logic di_i,
   output logic do_o
);

   if (ADDR_W < 2 || ADDR_W > 10) begin : g_bad_addr
      $error("mw_eeprom_slave: ADDR_W must be within 2..10");
   end
   if (DATA_W < 2) begin : g_bad_data
      $error("mw_eeprom_slave: DATA_W must be at least 2");
   end

   logic              cs_q;
   logic              di_q;
   logic              sck_rise;
   logic              cs_fall;
   logic              wr_one;
   logic              wr_all;
   logic [ADDR_W-1:0] wr_addr;
   logic [DATA_W-1:0] wr_data;
   logic [ADDR_W-1:0] rd_addr;
   logic [DATA_W-1:0] rd_data;

   mw_pin_sampler u_pins (
      .clk      (clk),
      .rst_n    (rst_n),
      .cs_i     (cs_i),
      .sck_i    (sck_i),
      .di_i     (di_i),
      .cs_q     (cs_q),
      .di_q     (di_q),
      .sck_rise (sck_rise),
      .cs_fall  (cs_fall)
   );

   mw_cmd_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .sck_rise (sck_rise),
      .cs_fall  (cs_fall),
      .di_q     (di_q),
      .rd_data  (rd_data),
      .do_o     (do_o),
      .wr_one   (wr_one),
      .wr_all   (wr_all),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .rd_addr  (rd_addr)
   );

   mw_word_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_one  (wr_one),
      .wr_all  (wr_all),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .rd_addr (rd_addr),
      .rd_data (rd_data)
   );

   // R2
   idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_q && $past(!cs_q)) |-> do_o);

endmodule

// File: tb/mw_eeprom_slave_tb_top.sv
`timescale 1ns/1ps
module mw_eeprom_slave_tb_top;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cs_i = 1'b0;
   logic sck_i = 1'b0;
   logic di_i = 1'b0;
   logic do_o;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   logic [15:0] exp_mem [64];
   logic        exp_we;

   always #10 clk = ~clk;

   mw_eeprom_slave dut_i (
      .clk   (clk),
      .rst_n (rst_n),
      .cs_i  (cs_i),
      .sck_i (sck_i),
      .di_i  (di_i),
      .do_o  (do_o)
   );

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles == 150000) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=%0d cycles expected=completion", cycles);
         summary();
         $finish;
      end
   end

   task automatic chk(input logic ok, input string tag, input logic [15:0] act,
                      input logic [15:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic shift_bit(input logic d, output logic q);
      di_i = d;
      repeat (3) @(negedge clk);
      sck_i = 1'b1;
      repeat (3) @(negedge clk);
      q = do_o;
      sck_i = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   task automatic cs_up();
      cs_i = 1'b1;
      repeat (3) @(negedge clk);
   endtask

   task automatic cs_down();
      cs_i = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   task automatic send_cmd(input logic [1:0] op, input logic [5:0] a, output logic q);
      logic [7:0] c;
      c = {op, a};
      cs_up();
      shift_bit(1'b1, q);
      for (int i = 7; i >= 0; i--) shift_bit(c[i], q);
   endtask

   task automatic shift_word(input logic [15:0] d);
      logic q;
      for (int i = 15; i >= 0; i--) shift_bit(d[i], q);
   endtask

   task automatic read_check(input logic [5:0] a, input int n, input string tag);
      logic q;
      logic [15:0] w;
      send_cmd(2'b10, a, q);
      chk(q == 1'b0, "R5 dummy zero", {15'd0, q}, 16'd0);
      for (int k = 0; k < n; k++) begin
         w = '0;
         for (int b = 0; b < 16; b++) begin
            shift_bit(1'b0, q);
            w = {w[14:0], q};
         end
         chk(w == exp_mem[6'(a + k)], tag, w, exp_mem[6'(a + k)]);
      end
      cs_down();
      chk(do_o == 1'b1, "R2 ready after release", {15'd0, do_o}, 16'd1);
   endtask

   task automatic do_write(input logic [5:0] a, input logic [15:0] d);
      logic q;
      send_cmd(2'b01, a, q);
      shift_word(d);
      cs_down();
      if (exp_we) exp_mem[a] = d;
   endtask

   task automatic do_write_all(input logic [15:0] d);
      logic q;
      send_cmd(2'b00, 6'b01_0000, q);
      shift_word(d);
      cs_down();
      if (exp_we) for (int i = 0; i < 64; i++) exp_mem[i] = d;
   endtask

   task automatic do_erase(input logic [5:0] a);
      logic q;
      send_cmd(2'b11, a, q);
      cs_down();
      if (exp_we) exp_mem[a] = 16'hFFFF;
   endtask

   task automatic do_erase_all();
      logic q;
      send_cmd(2'b00, 6'b10_0000, q);
      cs_down();
      if (exp_we) for (int i = 0; i < 64; i++) exp_mem[i] = 16'hFFFF;
   endtask

   task automatic set_we(input logic en);
      logic q;
      send_cmd(2'b00, en ? 6'b11_0000 : 6'b00_0000, q);
      cs_down();
      exp_we = en;
   endtask

   task automatic t_reset();
      chk(do_o == 1'b1, "R1 do_o after reset", {15'd0, do_o}, 16'd1);
      read_check(6'd0, 2, "R1 erased after reset");
      do_write(6'd5, 16'hAAAA);
      read_check(6'd5, 1, "R7 R1 write refused after reset");
   endtask

   task automatic t_write_seq();
      set_we(1'b1);
      do_write(6'd5, 16'hA5C3);
      do_write(6'd63, 16'h1234);
      do_write(6'd0, 16'hBEEF);
      do_write(6'd1, 16'h0F0F);
      do_write(6'd62, 16'h8001);
      read_check(6'd5, 1, "R7 R4 R11 stored word");
      read_check(6'd62, 4, "R6 sequential wrap 63 to 0");
   endtask

   task automatic t_protect();
      set_we(1'b0);
      do_write(6'd5, 16'h0000);
      do_erase(6'd0);
      do_erase_all();
      do_write_all(16'h0000);
      read_check(6'd5, 1, "R11 R7 write disabled");
      read_check(6'd0, 2, "R9 R10 R8 erase and fill refused");
   endtask

   task automatic t_erase();
      set_we(1'b1);
      do_erase(6'd5);
      read_check(6'd4, 3, "R9 single erase");
   endtask

   task automatic t_hold();
      logic q;
      send_cmd(2'b11, 6'd62, q);
      if (exp_we) exp_mem[62] = 16'hFFFF;
      shift_bit(1'b1, q);
      chk(q == 1'b1, "R12 do_o high in hold", {15'd0, q}, 16'd1);
      for (int i = 7; i >= 0; i--) shift_bit(((8'b01_000001 >> i) & 8'd1) != 0, q);
      chk(q == 1'b1, "R12 do_o high after command bits", {15'd0, q}, 16'd1);
      for (int i = 0; i < 16; i++) shift_bit(1'b0, q);
      chk(q == 1'b1, "R12 do_o high after data bits", {15'd0, q}, 16'd1);
      cs_down();
      read_check(6'd62, 4, "R12 clocks in hold ignored");
   endtask

   task automatic t_cs_gate();
      logic q;
      logic [15:0] w;
      cs_i = 1'b0;
      shift_bit(1'b1, q);
      for (int i = 7; i >= 0; i--) shift_bit(((8'b11_000000 >> i) & 8'd1) != 0, q);
      chk(q == 1'b1, "R13 do_o with select low", {15'd0, q}, 16'd1);
      read_check(6'd0, 1, "R13 clocks with select low ignored");
      cs_up();
      shift_bit(1'b0, q);
      shift_bit(1'b0, q);
      shift_bit(1'b0, q);
      chk(q == 1'b1, "R3 leading zeros keep idle", {15'd0, q}, 16'd1);
      shift_bit(1'b1, q);
      for (int i = 7; i >= 0; i--) shift_bit(((8'b10_000001 >> i) & 8'd1) != 0, q);
      chk(q == 1'b0, "R3 R5 dummy after late start", {15'd0, q}, 16'd0);
      w = '0;
      for (int b = 0; b < 16; b++) begin
         shift_bit(1'b0, q);
         w = {w[14:0], q};
      end
      chk(w == exp_mem[1], "R3 R4 read after leading zeros", w, exp_mem[1]);
      cs_down();
   endtask

   task automatic t_write_all();
      do_write_all(16'h5A5A);
      read_check(6'd17, 64, "R8 write-all whole array");
   endtask

   task automatic t_erase_all();
      do_erase_all();
      read_check(6'd40, 64, "R10 erase-all whole array");
   endtask

   initial begin
      for (int i = 0; i < 64; i++) exp_mem[i] = 16'hFFFF;
      exp_we = 1'b0;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      t_reset();
      t_write_seq();
      t_protect();
      t_erase();
      t_hold();
      t_cs_gate();
      t_write_all();
      t_erase_all();
      summary();
      $finish;
   end

endmodule